// File: doc/BRIEF.md
# Byte-Invariant Big-Endian Lane Swapper

This block sits on a 32-bit load/store data path between the core and memory. The core always holds its data in little-endian lane order. When the part is configured for big-endian memory, the block reorders the byte lanes of outgoing write data and incoming read data so that each byte address maps to a fixed lane (byte-invariant big endian). The reordering depends on the access size and on the low address bits. Lanes that take no part in the access are driven to zero.

The endianness choice is a configuration input. It is captured on every clock while reset is held and frozen from reset release until the next reset. Two kinds of access are always handled as little endian, whatever the mode: instruction fetches, and any access whose address has its top three bits all ones (0xE0000000 upward). The data path is combinational. Only the mode flag is a register.

Top module: `endian_lane_swap`

## Requirements
- R1: The mode flag is loaded from `cfg_big_endian_i` on every rising clock edge where `rst_n` is low. After reset release, changes on `cfg_big_endian_i` have no effect until the next reset.
- R2: Size encoding is 0 = byte, 1 = halfword, 2 or 3 = word. Active little-endian lanes (lane k = bits 8k+7..8k) are as follows. A byte uses lane `acc_addr_i[1:0]`. A halfword uses lanes 1..0 when `acc_addr_i[1]` is 0 and lanes 3..2 when it is 1; `acc_addr_i[0]` is ignored. A word uses all four lanes; `acc_addr_i[1:0]` is ignored.
- R3: On both `wdata_o` and `rdata_o`, every lane that the access does not use is zero.
- R4: In little-endian mode, active lanes pass through on the same lane, for writes and for reads.
- R5: For a big-endian word write, `wdata_o` = {in[7:0], in[15:8], in[23:16], in[31:24]}.
- R6: For a big-endian halfword write at offset 0, in[7:0] goes to bits 31..24 and in[15:8] goes to bits 23..16. At offset 2, in[23:16] goes to bits 15..8 and in[31:24] goes to bits 7..0.
- R7: For a big-endian byte write, little-endian lane k is moved to lane 3-k.
- R8: When `acc_fetch_i` is 1, the access is handled as little endian in either mode.
- R9: When `acc_addr_i[31:29]` is 3'b111, the access is handled as little endian in either mode. An address of 0xDFFFFFFC is still swapped.
- R10: The read path is the inverse of the write path. `rdata_o` lane k takes the memory lane that the write path would have driven from lane k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_big_endian_i | input | 1 | Endianness choice, 1 = big endian, captured during reset |
| acc_addr_i | input | 32 | Byte address of the current access |
| acc_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| wdata_i | input | 32 | Write data from the core, little-endian lanes |
| wdata_o | output | 32 | Write data to memory, lane-ordered for the mode |
| rdata_i | input | 32 | Read data from memory |
| rdata_o | output | 32 | Read data to the core, little-endian lanes |

## Verification
A big-endian swap and a forced-little-endian exception can apply to the same access. The bench provokes this with big-endian sub-word and word accesses that are fetches, that target the top address region, or both. It also places accesses on either side of the 0xE0000000 boundary. A behavioural byte-address model predicts every lane. Each vector is judged on both outputs in the same cycle. Reset capture and a post-reset change of the configuration input also fall on cycles that carry accesses. The expected outputs there must follow the frozen mode.

// File: rtl/endian_pkg.sv
`timescale 1ns/1ps
// Shared types for the lane swapper.
// Assumes a 32-bit data path made of four byte lanes.
package endian_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } acc_size_e;

    localparam int LANE_W  = 8;
    localparam int N_LANES = 4;
endpackage

// File: rtl/endian_mode_latch.sv
`timescale 1ns/1ps
// Holds the endianness mode. The mode is loaded while reset is active and
// frozen afterwards. Assumes rst_n is synchronous to clk.
module endian_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_be_i,
    output logic mode_be_o
);
    // capture the configuration only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_be_o <= cfg_be_i;
        end
    end

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_be_o)); // R1
endmodule

// File: rtl/endian_lane_ctrl.sv
`timescale 1ns/1ps
// Decodes the active little-endian lanes from size and address. Decides
// whether the access is swapped: big-endian mode, not a fetch, and not in
// the top system region. Assumes a 4-lane bus.
module endian_lane_ctrl
    import endian_pkg::*;
#(
    parameter int              ADDR_W  = 32,
    parameter int              SYS_W   = 3,
    parameter logic [SYS_W-1:0] SYS_TAG = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              fetch_i,
    input  logic              mode_be_i,
    output logic [N_LANES-1:0] lane_en_o,
    output logic              swap_o
);
    logic in_sys;

    // lane enables in little-endian lane coordinates
    always_comb begin
        lane_en_o = '0;
        unique case (acc_size_e'(size_i))
            SZ_BYTE: lane_en_o[addr_i[1:0]] = 1'b1;
            SZ_HALF: lane_en_o = addr_i[1] ? 4'b1100 : 4'b0011;
            default: lane_en_o = 4'b1111;
        endcase
    end

    // forced little-endian checks and the final swap decision
    always_comb begin
        in_sys = (addr_i[ADDR_W-1 -: SYS_W] == SYS_TAG);
        swap_o = mode_be_i && !fetch_i && !in_sys;
    end

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_BYTE) |-> ($countones(lane_en_o) == 1)); // R2
    AST_FETCH_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_i |-> !swap_o); // R8
endmodule

// File: rtl/endian_byte_router.sv
`timescale 1ns/1ps
// Moves byte lanes straight or mirrored (lane j <-> lane 3-j) and zeroes
// the unused lanes. MASK_SRC=1 qualifies a lane by its source position
// (write path); MASK_SRC=0 qualifies it by its destination (read path).
module endian_byte_router
    import endian_pkg::*;
#(
    parameter bit MASK_SRC = 1'b1
) (
    input  logic [N_LANES*LANE_W-1:0] data_i,
    input  logic [N_LANES-1:0]        lane_en_i,
    input  logic                      swap_i,
    output logic [N_LANES*LANE_W-1:0] data_o
);
    for (genvar j = 0; j < N_LANES; j++) begin : g_lane
        localparam int MIR = N_LANES - 1 - j;
        logic keep;
        // pick the enable that governs this output lane
        always_comb begin
            if (MASK_SRC) keep = swap_i ? lane_en_i[MIR] : lane_en_i[j];
            else          keep = lane_en_i[j];
        end
        // route one byte lane
        always_comb begin
            if (!keep)       data_o[j*LANE_W +: LANE_W] = '0;
            else if (swap_i) data_o[j*LANE_W +: LANE_W] = data_i[MIR*LANE_W +: LANE_W];
            else             data_o[j*LANE_W +: LANE_W] = data_i[j*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/endian_lane_swap.sv
`timescale 1ns/1ps
// Byte-invariant big-endian lane swapper for a 32-bit load/store path.
// Write data is reordered on the way out and read data on the way in.
// The mode is frozen at reset; fetches and the top system region stay
// little endian. The data path is combinational.
module endian_lane_swap
    import endian_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SYS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_endian_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [1:0]        acc_size_i,
    input  logic              acc_fetch_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       wdata_o,
    input  logic [31:0]       rdata_i,
    output logic [31:0]       rdata_o
);
    localparam int DATA_W = N_LANES * LANE_W;

    logic              mode_be;
    logic [N_LANES-1:0] lane_en;
    logic              swap;
    logic [DATA_W-1:0] lane_bits;

    endian_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_be_i  (cfg_big_endian_i),
        .mode_be_o (mode_be)
    );

    endian_lane_ctrl #(.ADDR_W(ADDR_W), .SYS_W(SYS_W), .SYS_TAG('1)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (acc_addr_i),
        .size_i    (acc_size_i),
        .fetch_i   (acc_fetch_i),
        .mode_be_i (mode_be),
        .lane_en_o (lane_en),
        .swap_o    (swap)
    );

    endian_byte_router #(.MASK_SRC(1'b1)) u_wr (
        .data_i    (wdata_i),
        .lane_en_i (lane_en),
        .swap_i    (swap),
        .data_o    (wdata_o)
    );

    endian_byte_router #(.MASK_SRC(1'b0)) u_rd (
        .data_i    (rdata_i),
        .lane_en_i (lane_en),
        .swap_i    (swap),
        .data_o    (rdata_o)
    );

    // bit-wide copy of the lane enables, used only by the checks below
    for (genvar k = 0; k < N_LANES; k++) begin : g_bits
        assign lane_bits[k*LANE_W +: LANE_W] = {LANE_W{lane_en[k]}};
    end

    AST_FETCH_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fetch_i |-> (wdata_o == (wdata_i & lane_bits))); // R8
    AST_SYS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (&acc_addr_i[ADDR_W-1 -: SYS_W]) |-> (rdata_o == (rdata_i & lane_bits))); // R9
    AST_BE_WORD_REV: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_be && !acc_fetch_i && !(&acc_addr_i[ADDR_W-1 -: SYS_W]) && acc_size_i[1])
        |-> (wdata_o == {wdata_i[7:0], wdata_i[15:8], wdata_i[23:16], wdata_i[31:24]})); // R5
    AST_READ_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_i == wdata_o) |-> (rdata_o == (wdata_i & lane_bits))); // R10
    AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~lane_bits) == '0); // R3
endmodule

// File: tb/sim_endian_lane_swap.sv
`timescale 1ns/1ps
module sim_endian_lane_swap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic        fetch = 1'b0;
    logic [31:0] wd = '0, rd = '0;
    logic [31:0] wo, ro;
    int          n_vec = 0;
    int          n_bad = 0;
    logic        mdl_be;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    endian_lane_swap u0 (
        .clk(clk), .rst_n(rst_n), .cfg_big_endian_i(cfg),
        .acc_addr_i(addr), .acc_size_i(size), .acc_fetch_i(fetch),
        .wdata_i(wd), .wdata_o(wo), .rdata_i(rd), .rdata_o(ro)
    );

    // reference mode: follows the configuration only while reset is low
    always @(posedge clk) if (!rst_n) mdl_be <= cfg;

    // behavioural byte-address model of one path
    function automatic logic [31:0] model(input logic be, input logic [31:0] a,
                                          input logic [1:0] s, input logic f,
                                          input logic [31:0] d, input bit is_rd);
        logic [3:0]  act = '0;
        logic [31:0] res = '0;
        bit          rev;
        if (s == 2'd0)      act[a[1:0]] = 1'b1;
        else if (s == 2'd1) act = a[1] ? 4'b1100 : 4'b0011;
        else                act = 4'b1111;
        rev = be && !f && (a[31:29] != 3'b111);
        for (int k = 0; k < 4; k++) begin
            int m;
            m = rev ? 3 - k : k;
            if (act[k]) begin
                if (is_rd) res[k*8 +: 8] = d[m*8 +: 8];
                else       res[m*8 +: 8] = d[k*8 +: 8];
            end
        end
        return res;
    endfunction

    task automatic apply(input logic f, input logic [31:0] a, input logic [1:0] s,
                         input logic [31:0] w, input logic [31:0] r, input string tag);
        logic [31:0] ew, er;
        @(posedge clk);
        #1;
        fetch = f; addr = a; size = s; wd = w; rd = r;
        @(negedge clk);
        ew = model(mdl_be, a, s, f, w, 1'b0);
        er = model(mdl_be, a, s, f, r, 1'b1);
        n_vec++;
        if (wo !== ew || ro !== er) begin
            n_bad++;
            $display("FAIL %s R3 R10 addr=%h size=%0d: wdata_o=%h exp %h, rdata_o=%h exp %h",
                     tag, a, s, wo, ew, ro, er);
        end
    endtask

    task automatic do_reset(input logic be);
        rst_n = 1'b0; cfg = be;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    function automatic string pick(input logic f, input logic [31:0] a, input logic [1:0] s);
        if (!mdl_be)          return "R4";
        if (f)                return "R8";
        if (a[31:29] == 3'b111) return "R9";
        if (s == 2'd0)        return "R7";
        if (s == 2'd1)        return "R6";
        return "R5";
    endfunction

    initial begin
        #(5.0 * 200000);
        $display("FAIL watchdog expired, R1 run incomplete: actual hung, expected finish");
        n_bad++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: big-endian captured in reset, then configuration changes
        do_reset(1'b1);
        apply(1'b0, 32'h2000_0000, 2'd2, 32'h3355_AACC, 32'hCCAA_5533, "R1 R5");
        cfg = 1'b0;
        apply(1'b0, 32'h2000_0000, 2'd2, 32'h1122_3344, 32'h5566_7788, "R1 frozen");
        // R6 and R2: halfwords, offset bit 0 ignored
        apply(1'b0, 32'h2000_0000, 2'd1, 32'hDEAD_BEEF, 32'hA1B2_C3D4, "R6 off0");
        apply(1'b0, 32'h2000_0002, 2'd1, 32'hDEAD_BEEF, 32'hA1B2_C3D4, "R6 off2");
        apply(1'b0, 32'h2000_0003, 2'd1, 32'hDEAD_BEEF, 32'hA1B2_C3D4, "R2 R6 a0");
        // R7: each byte lane
        for (int b = 0; b < 4; b++)
            apply(1'b0, 32'h4000_0000 | b, 2'd0, 32'h0102_0304, 32'h0A0B_0C0D, "R7");
        // R2: size 3 and unaligned word address
        apply(1'b0, 32'h2000_0001, 2'd3, 32'hCAFE_F00D, 32'h1234_5678, "R2 R5");
        // R8/R9 combined with big-endian swap conditions
        apply(1'b1, 32'h0000_0002, 2'd1, 32'hCAFE_F00D, 32'h1234_5678, "R8");
        apply(1'b1, 32'h0000_0100, 2'd2, 32'hCAFE_F00D, 32'h1234_5678, "R8");
        apply(1'b0, 32'hE000_E010, 2'd2, 32'hCAFE_F00D, 32'h1234_5678, "R9");
        apply(1'b0, 32'hE000_0001, 2'd0, 32'hCAFE_F00D, 32'h1234_5678, "R9");
        apply(1'b0, 32'hDFFF_FFFC, 2'd2, 32'hCAFE_F00D, 32'h1234_5678, "R9 edge");
        apply(1'b1, 32'hFFFF_FFFE, 2'd1, 32'hCAFE_F00D, 32'h1234_5678, "R8 R9");
        // random big-endian traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic f;
            logic [1:0] s;
            a = $urandom; f = ($urandom % 5) == 0; s = 2'($urandom);
            apply(f, a, s, $urandom, $urandom, pick(f, a, s));
        end
        // R1 and R4: re-reset into little endian
        do_reset(1'b0);
        apply(1'b0, 32'h2000_0000, 2'd2, 32'h3355_AACC, 32'h0BAD_CAFE, "R1 R4");
        cfg = 1'b1;
        apply(1'b0, 32'h2000_0002, 2'd1, 32'h3355_AACC, 32'h0BAD_CAFE, "R1 R4");
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            a = $urandom;
            apply(1'(($urandom % 4) == 0), a, 2'($urandom), $urandom, $urandom, "R4");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule